// File: doc/BRIEF.md
# Banked Data-Memory Address Generator

This block turns the short register operand of an instruction into a full data-memory address. The data space is 4096 bytes, seen as sixteen banks of 256 bytes. An instruction carries only an 8-bit register field and a single mode bit. In bank mode, the field is an offset inside the bank held in a 4-bit bank register. In direct-window mode, the field reaches a fixed window that is always visible. This window joins the lowest 96 general-purpose bytes to the highest 160 bytes, where the special-function registers live.

The bank register is kept inside the block. A load strobe writes it from a literal. The address path is purely combinational from the request inputs and the stored bank value. The block also raises a flag whenever the address it resolves falls in the special-function region at the top of the space. The memory array, pointer-based indirect access and two-word absolute moves sit outside this block.

Top module: `bank_addr_gen`

## Requirements
- R1: After reset the bank register holds 0, so a bank-mode request with field value v resolves to address 0x000 + v.
- R2: With bank_mode = 1 and req = 1, addr equals the bank register in bits 11:8 and reg_field in bits 7:0.
- R3: With bank_mode = 0 and reg_field below 0x60, addr equals reg_field with bits 11:8 set to zero (range 0x000 to 0x05F).
- R4: With bank_mode = 0 and reg_field at 0x60 or above, addr equals reg_field with bits 11:8 all ones (range 0xF60 to 0xFFF).
- R5: A bank load presented with bank_wr = 1 is captured on the rising clock edge. In that same cycle, requests still use the old bank value. The new value applies from the next cycle onward.
- R6: Only bank_wdata bits 3:0 are stored on a load. Bits 7:4 have no effect on any later address.
- R7: sfr_sel is 1 exactly when req = 1 and the resolved address is 0xF60 or higher. This includes bank mode with bank 15 and a field of 0x60 or more.
- R8: With req = 0, addr is 0x000 and sfr_sel is 0, whatever the other inputs are.
- R9: In direct-window mode, the address does not depend on the bank register value.
- R10: With bank_wr = 0, the bank register keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_field | input | 8 | Register operand from the instruction |
| bank_mode | input | 1 | 1 = offset within the selected bank, 0 = fixed direct window |
| bank_wr | input | 1 | Load strobe for the bank register |
| bank_wdata | input | 8 | Literal to load; only bits 3:0 are kept |
| req | input | 1 | Address request; outputs are meaningful only while high |
| addr | output | 12 | Resolved physical data address |
| sfr_sel | output | 1 | Resolved address lies in the special-function region |

## Verification
The assertions assume that the inputs are steady at each rising edge. They also assume that bank_wr is low while reset is active, so the bank register's first post-reset value is always the reset zero. The bench changes every input only on the falling edge and keeps the load strobe low throughout reset. It samples the combinational outputs one nanosecond after each change. It checks bank loads twice: in the cycle the strobe is high, and again after the capturing edge.

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
  parameter int FIELD_W = 8,
  parameter int BANK_W  = 4,
  parameter logic [FIELD_W-1:0] LOW_SPLIT = 8'h60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] reg_field,
  input  logic               bank_mode,
  input  logic               bank_wr,
  input  logic [FIELD_W-1:0] bank_wdata,
  input  logic               req,
  output logic [BANK_W+FIELD_W-1:0] addr,
  output logic               sfr_sel
);

  localparam int ADDR_W = BANK_W + FIELD_W;
  localparam logic [ADDR_W-1:0] SFR_BASE = {{BANK_W{1'b1}}, LOW_SPLIT};

  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_wr) bank_q <= bank_wdata[BANK_W-1:0];
  end

  always_comb begin
    if (bank_mode)                  page = bank_q;
    else if (reg_field < LOW_SPLIT) page = '0;
    else                            page = '1;
  end

  assign addr    = req ? {page, reg_field} : '0;
  assign sfr_sel = req && (addr >= SFR_BASE);

  // R5
  bank_load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> (bank_q == $past(bank_wdata[BANK_W-1:0])));

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> $stable(bank_q));

  // R3
  window_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !bank_mode && reg_field < LOW_SPLIT) |-> (addr < ADDR_W'(LOW_SPLIT)));

  // R4
  window_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !bank_mode && reg_field >= LOW_SPLIT) |-> sfr_sel);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (addr == '0 && !sfr_sel));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (addr[FIELD_W-1:0] == reg_field));

endmodule

// File: tb/bank_addr_gen_bench.sv
module bank_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_field = '0;
  logic        bank_mode = 1'b0;
  logic        bank_wr = 1'b0;
  logic [7:0]  bank_wdata = '0;
  logic        req = 1'b0;
  logic [11:0] addr;
  logic        sfr_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_addr_gen u_bank_addr_gen (
    .clk(clk), .rst_n(rst_n), .reg_field(reg_field), .bank_mode(bank_mode),
    .bank_wr(bank_wr), .bank_wdata(bank_wdata), .req(req),
    .addr(addr), .sfr_sel(sfr_sel)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [7:0] f, input logic r);
    @(negedge clk);
    bank_mode = m; reg_field = f; req = r;
    #1;
  endtask

  task automatic load_bank(input logic [7:0] v);
    @(negedge clk);
    bank_wr = 1'b1; bank_wdata = v;
    @(negedge clk);
    bank_wr = 1'b0;
  endtask

  task automatic t_reset;
    drive(1'b1, 8'h42, 1'b1);
    chk("R1 bank zero after reset", addr, 12'h042);
    chk("R1 no sfr after reset", {11'd0, sfr_sel}, 12'h000);
  endtask

  task automatic t_banked;
    for (int b = 1; b < 16; b += 5) begin
      load_bank(8'(b));
      drive(1'b1, 8'h9C, 1'b1);
      chk("R2 banked address", addr, {4'(b), 8'h9C});
    end
  endtask

  task automatic t_window;
    load_bank(8'h07);
    drive(1'b0, 8'h00, 1'b1);
    chk("R3 window bottom", addr, 12'h000);
    drive(1'b0, 8'h5F, 1'b1);
    chk("R3 window last low", addr, 12'h05F);
    chk("R7 low window no sfr", {11'd0, sfr_sel}, 12'h000);
    drive(1'b0, 8'h60, 1'b1);
    chk("R4 window first high", addr, 12'hF60);
    chk("R7 high window sfr", {11'd0, sfr_sel}, 12'h001);
    drive(1'b0, 8'hFF, 1'b1);
    chk("R4 window top", addr, 12'hFFF);
    load_bank(8'h0C);
    drive(1'b0, 8'h31, 1'b1);
    chk("R9 window ignores bank low", addr, 12'h031);
    drive(1'b0, 8'hA5, 1'b1);
    chk("R9 window ignores bank high", addr, 12'hFA5);
  endtask

  task automatic t_load_timing;
    load_bank(8'h02);
    @(negedge clk);
    bank_wr = 1'b1; bank_wdata = 8'h09;
    bank_mode = 1'b1; reg_field = 8'h10; req = 1'b1;
    #1;
    chk("R5 old bank during load cycle", addr, 12'h210);
    @(negedge clk);
    bank_wr = 1'b0;
    #1;
    chk("R5 new bank after edge", addr, 12'h910);
    @(negedge clk); @(negedge clk);
    #1;
    chk("R10 bank held without strobe", addr, 12'h910);
  endtask

  task automatic t_load_mask;
    load_bank(8'hA3);
    drive(1'b1, 8'h55, 1'b1);
    chk("R6 upper literal bits ignored", addr, 12'h355);
    load_bank(8'hF0);
    drive(1'b1, 8'h01, 1'b1);
    chk("R6 upper literal bits ignored zero", addr, 12'h001);
  endtask

  task automatic t_sfr_banked;
    load_bank(8'h0F);
    drive(1'b1, 8'h60, 1'b1);
    chk("R7 bank 15 sfr start", {11'd0, sfr_sel}, 12'h001);
    drive(1'b1, 8'h5F, 1'b1);
    chk("R7 bank 15 below sfr", {11'd0, sfr_sel}, 12'h000);
    load_bank(8'h0E);
    drive(1'b1, 8'hFF, 1'b1);
    chk("R7 bank 14 not sfr", {11'd0, sfr_sel}, 12'h000);
  endtask

  task automatic t_idle;
    load_bank(8'h0F);
    drive(1'b1, 8'hEE, 1'b0);
    chk("R8 idle address zero", addr, 12'h000);
    chk("R8 idle no sfr", {11'd0, sfr_sel}, 12'h000);
    drive(1'b0, 8'hFF, 1'b0);
    chk("R8 idle window zero", addr, 12'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_banked();
    t_window();
    t_load_timing();
    t_load_mask();
    t_sfr_banked();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule